// File: doc/BRIEF.md
# Reorder Buffer with Per-Entry Lifecycle

This block is the reorder buffer of a small speculative out-of-order core. Decoded instructions are written at the tail together with their opcode, destination register, a flag that marks them as memory operations, and two source operands. Each operand is either a value already read from the register file or the tag of the buffer entry that will produce it. Each entry steps through five states: empty, waiting, dispatched, killed and done. Two independent dispatch ports hand out ready work. One serves the ALU and one serves the memory unit. Each offers the oldest eligible entry, counted from the head.

Results come back from the two units by tag and mark their entry done. Each accepted result is also forwarded to every waiting operand that names the producing tag. A resolved mispredicted branch marks every entry younger than itself as killed. Retirement leaves from the head in program order. A done entry writes its result to the register file. A killed entry is dropped without a write. The register file, the decoder and the execution units are outside this block.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `ins_ready_o` is 1, and `alu_valid_o`, `mem_valid_o` and `ret_valid_o` are 0.
- R2: An accepted insert (`ins_valid_i` and `ins_ready_o`) writes the tail slot, enters the waiting state and receives tag `ins_tag_o`, the tail index. Tags count up modulo DEPTH (16) and wrap. `ins_ready_o` is 0 while DEPTH entries are held, and an insert offered then adds no entry.
- R3: `alu_valid_o` is 1 when some waiting entry with `ins_mem_i`=0 has both operands valid. The port then presents the oldest such entry, counted from the head, with its tag, opcode and operands. A handshake moves that entry to dispatched, and it is not offered again.
- R4: The memory port behaves as in R3 for entries inserted with `ins_mem_i`=1, independently of the ALU port and possibly in the same cycle.
- R5: A write-back from either unit whose tag names a dispatched entry stores the data and marks the entry done. If both units name the same tag in one cycle, the ALU data is kept. A write-back naming an entry in any other state has no effect.
- R6: An accepted write-back also fills, from the next cycle, every invalid operand of a waiting entry that names the written tag. An operand inserted as not valid is captured at insert time if its producer is already done, or is written back in that same cycle.
- R7: `ret_valid_o` is 1 when the head entry is done or killed. Retirement follows program order. A done head gives `ret_we_o`=1 with its destination and result, and a handshake frees the slot.
- R8: `kill_valid_i` marks as killed every occupied entry younger than `kill_tag_i`. The branch entry and older entries are unaffected. Killed entries are never dispatched, ignore their write-backs and retire with `ret_we_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Decode offers an instruction |
| ins_ready_o | output | 1 | Buffer not full |
| ins_tag_o | output | IDX_W | Tag the offered instruction receives |
| ins_op_i | input | OP_W | Opcode |
| ins_mem_i | input | 1 | 1: memory instruction, 0: ALU instruction |
| ins_dst_i | input | REG_W | Destination register |
| ins_a_i | input | DATA_W | Operand A value from the register file |
| ins_a_ok_i | input | 1 | Operand A value present |
| ins_a_tag_i | input | IDX_W | Producer tag of operand A when not present |
| ins_b_i | input | DATA_W | Operand B value from the register file |
| ins_b_ok_i | input | 1 | Operand B value present |
| ins_b_tag_i | input | IDX_W | Producer tag of operand B when not present |
| alu_valid_o | output | 1 | An ALU entry is ready to issue |
| alu_ready_i | input | 1 | ALU accepts the offered entry |
| alu_tag_o | output | IDX_W | Tag of the offered ALU entry |
| alu_op_o | output | OP_W | Its opcode |
| alu_a_o | output | DATA_W | Its operand A |
| alu_b_o | output | DATA_W | Its operand B |
| mem_valid_o | output | 1 | A memory entry is ready to issue |
| mem_ready_i | input | 1 | Memory unit accepts the offered entry |
| mem_tag_o | output | IDX_W | Tag of the offered memory entry |
| mem_op_o | output | OP_W | Its opcode |
| mem_a_o | output | DATA_W | Its operand A |
| mem_b_o | output | DATA_W | Its operand B |
| alu_wb_valid_i | input | 1 | ALU result present |
| alu_wb_tag_i | input | IDX_W | Tag of the ALU result |
| alu_wb_data_i | input | DATA_W | ALU result value |
| mem_wb_valid_i | input | 1 | Memory result present |
| mem_wb_tag_i | input | IDX_W | Tag of the memory result |
| mem_wb_data_i | input | DATA_W | Memory result value |
| kill_valid_i | input | 1 | Mispredicted branch resolved |
| kill_tag_i | input | IDX_W | Tag of that branch |
| ret_valid_o | output | 1 | Head entry can retire |
| ret_ready_i | input | 1 | Retirement accepted |
| ret_we_o | output | 1 | Retirement writes the register file |
| ret_dst_o | output | REG_W | Destination register of the head |
| ret_data_o | output | DATA_W | Result of the head |

## Verification
The bench aims at the dependency paths. It checks a consumer that must wake through the result broadcast, and one that must take its value at insert time from a producer that is already done. A design that missed either would leave the consumer stuck in waiting and never offer it. It writes back to an entry that is still waiting and to an entry that was killed. A design that did not check the dispatched state would mark these done and retire them with a register write or the wrong data. It kills entries both in flight and still waiting, and checks that the branch itself survives. It then fills the buffer across the pointer wrap, so that a wrong full test or a wrong oldest-first search shows up as an accepted insert or as a tag out of order.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;
  typedef enum logic [2:0] {
    ST_EMPTY = 3'd0,
    ST_WAIT  = 3'd1,
    ST_DISP  = 3'd2,
    ST_KILL  = 3'd3,
    ST_DONE  = 3'd4
  } rob_st_e;
endpackage

// File: rtl/rob_pick.sv
`timescale 1ns/1ps
// Oldest-first selector: scans from head around the ring (DEPTH a power of two).
module rob_pick #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] elig_i,
  input  logic [IDX_W-1:0] head_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    logic [IDX_W-1:0] pos;
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      pos = head_i + IDX_W'(k);
      if (!found_o && elig_i[pos]) begin
        found_o = 1'b1;
        idx_o   = pos;
      end
    end
  end
endmodule

// File: rtl/rob_kill_mask.sv
`timescale 1ns/1ps
// Marks occupied slots strictly younger than the branch tag.
module rob_kill_mask #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic [IDX_W-1:0] head_i,
  input  logic [PTR_W-1:0] count_i,
  input  logic [IDX_W-1:0] kill_tag_i,
  output logic [DEPTH-1:0] mask_o
);
  always_comb begin
    logic [IDX_W-1:0] dk;
    logic [IDX_W-1:0] dj;
    dk = kill_tag_i - head_i;
    for (int j = 0; j < DEPTH; j++) begin
      dj = IDX_W'(j) - head_i;
      mask_o[j] = (dj > dk) && ({1'b0, dj} < count_i);
    end
  end
endmodule

// File: rtl/rob_core.sv
`timescale 1ns/1ps
module rob_core import rob_pkg::*; #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int OP_W   = 8,
  parameter int REG_W  = 5,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ins_valid_i,
  output logic              ins_ready_o,
  output logic [IDX_W-1:0]  ins_tag_o,
  input  logic [OP_W-1:0]   ins_op_i,
  input  logic              ins_mem_i,
  input  logic [REG_W-1:0]  ins_dst_i,
  input  logic [DATA_W-1:0] ins_a_i,
  input  logic              ins_a_ok_i,
  input  logic [IDX_W-1:0]  ins_a_tag_i,
  input  logic [DATA_W-1:0] ins_b_i,
  input  logic              ins_b_ok_i,
  input  logic [IDX_W-1:0]  ins_b_tag_i,
  output logic              alu_valid_o,
  input  logic              alu_ready_i,
  output logic [IDX_W-1:0]  alu_tag_o,
  output logic [OP_W-1:0]   alu_op_o,
  output logic [DATA_W-1:0] alu_a_o,
  output logic [DATA_W-1:0] alu_b_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [IDX_W-1:0]  mem_tag_o,
  output logic [OP_W-1:0]   mem_op_o,
  output logic [DATA_W-1:0] mem_a_o,
  output logic [DATA_W-1:0] mem_b_o,
  input  logic              alu_wb_valid_i,
  input  logic [IDX_W-1:0]  alu_wb_tag_i,
  input  logic [DATA_W-1:0] alu_wb_data_i,
  input  logic              mem_wb_valid_i,
  input  logic [IDX_W-1:0]  mem_wb_tag_i,
  input  logic [DATA_W-1:0] mem_wb_data_i,
  input  logic              kill_valid_i,
  input  logic [IDX_W-1:0]  kill_tag_i,
  output logic              ret_valid_o,
  input  logic              ret_ready_i,
  output logic              ret_we_o,
  output logic [REG_W-1:0]  ret_dst_o,
  output logic [DATA_W-1:0] ret_data_o
);

  rob_st_e           st_q   [DEPTH];
  logic              mem_q  [DEPTH];
  logic [OP_W-1:0]   op_q   [DEPTH];
  logic [REG_W-1:0]  dst_q  [DEPTH];
  logic [DATA_W-1:0] a_q    [DEPTH];
  logic [DATA_W-1:0] b_q    [DEPTH];
  logic              a_ok_q [DEPTH];
  logic              b_ok_q [DEPTH];
  logic [IDX_W-1:0]  a_tag_q[DEPTH];
  logic [IDX_W-1:0]  b_tag_q[DEPTH];
  logic [DATA_W-1:0] res_q  [DEPTH];

  logic [PTR_W-1:0] head_q, tail_q, count;
  logic [IDX_W-1:0] head_idx, tail_idx;
  logic             full;

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign count    = tail_q - head_q;
  assign full     = (count == PTR_W'(DEPTH));

  logic ins_fire, alu_fire, mem_fire, ret_fire;
  logic alu_wb_acc, mem_wb_acc;

  // A result counts only when its entry is in flight; ALU wins a tag clash.
  assign alu_wb_acc = alu_wb_valid_i && (st_q[alu_wb_tag_i] == ST_DISP);
  assign mem_wb_acc = mem_wb_valid_i && (st_q[mem_wb_tag_i] == ST_DISP) &&
                      !(alu_wb_acc && (alu_wb_tag_i == mem_wb_tag_i));

  // Eligibility and selection
  logic [DEPTH-1:0] elig_alu, elig_mem, kill_mask;
  logic             alu_found, mem_found;
  logic [IDX_W-1:0] alu_idx, mem_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_elig
    logic rdy;
    assign rdy         = (st_q[g] == ST_WAIT) && a_ok_q[g] && b_ok_q[g];
    assign elig_alu[g] = rdy && !mem_q[g];
    assign elig_mem[g] = rdy && mem_q[g];
  end

  rob_pick #(.DEPTH(DEPTH)) u_pick_alu (
    .elig_i(elig_alu), .head_i(head_idx), .found_o(alu_found), .idx_o(alu_idx)
  );
  rob_pick #(.DEPTH(DEPTH)) u_pick_mem (
    .elig_i(elig_mem), .head_i(head_idx), .found_o(mem_found), .idx_o(mem_idx)
  );
  rob_kill_mask #(.DEPTH(DEPTH)) u_kill (
    .head_i(head_idx), .count_i(count), .kill_tag_i(kill_tag_i), .mask_o(kill_mask)
  );

  assign ins_ready_o = !full;
  assign ins_tag_o   = tail_idx;
  assign ins_fire    = ins_valid_i && ins_ready_o;

  assign alu_valid_o = alu_found;
  assign alu_tag_o   = alu_idx;
  assign alu_op_o    = op_q[alu_idx];
  assign alu_a_o     = a_q[alu_idx];
  assign alu_b_o     = b_q[alu_idx];
  assign alu_fire    = alu_valid_o && alu_ready_i;

  assign mem_valid_o = mem_found;
  assign mem_tag_o   = mem_idx;
  assign mem_op_o    = op_q[mem_idx];
  assign mem_a_o     = a_q[mem_idx];
  assign mem_b_o     = b_q[mem_idx];
  assign mem_fire    = mem_valid_o && mem_ready_i;

  assign ret_valid_o = (st_q[head_idx] == ST_DONE) || (st_q[head_idx] == ST_KILL);
  assign ret_we_o    = (st_q[head_idx] == ST_DONE);
  assign ret_dst_o   = dst_q[head_idx];
  assign ret_data_o  = res_q[head_idx];
  assign ret_fire    = ret_valid_o && ret_ready_i;

  // Operand capture at insert: producer already done, or finishing this cycle.
  logic              cap_a_ok, cap_b_ok;
  logic [DATA_W-1:0] cap_a, cap_b;

  always_comb begin
    cap_a_ok = ins_a_ok_i;
    cap_a    = ins_a_i;
    if (!ins_a_ok_i) begin
      if (st_q[ins_a_tag_i] == ST_DONE) begin
        cap_a_ok = 1'b1; cap_a = res_q[ins_a_tag_i];
      end else if (alu_wb_acc && alu_wb_tag_i == ins_a_tag_i) begin
        cap_a_ok = 1'b1; cap_a = alu_wb_data_i;
      end else if (mem_wb_acc && mem_wb_tag_i == ins_a_tag_i) begin
        cap_a_ok = 1'b1; cap_a = mem_wb_data_i;
      end
    end
    cap_b_ok = ins_b_ok_i;
    cap_b    = ins_b_i;
    if (!ins_b_ok_i) begin
      if (st_q[ins_b_tag_i] == ST_DONE) begin
        cap_b_ok = 1'b1; cap_b = res_q[ins_b_tag_i];
      end else if (alu_wb_acc && alu_wb_tag_i == ins_b_tag_i) begin
        cap_b_ok = 1'b1; cap_b = alu_wb_data_i;
      end else if (mem_wb_acc && mem_wb_tag_i == ins_b_tag_i) begin
        cap_b_ok = 1'b1; cap_b = mem_wb_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]    <= ST_EMPTY;
        mem_q[i]   <= 1'b0;
        op_q[i]    <= '0;
        dst_q[i]   <= '0;
        a_q[i]     <= '0;
        b_q[i]     <= '0;
        a_ok_q[i]  <= 1'b0;
        b_ok_q[i]  <= 1'b0;
        a_tag_q[i] <= '0;
        b_tag_q[i] <= '0;
        res_q[i]   <= '0;
      end
    end else begin
      if (ins_fire) tail_q <= tail_q + 1'b1;
      if (ret_fire) head_q <= head_q + 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        // result broadcast into waiting operands
        if (st_q[i] == ST_WAIT) begin
          if (!a_ok_q[i]) begin
            if (alu_wb_acc && a_tag_q[i] == alu_wb_tag_i) begin
              a_q[i] <= alu_wb_data_i; a_ok_q[i] <= 1'b1;
            end else if (mem_wb_acc && a_tag_q[i] == mem_wb_tag_i) begin
              a_q[i] <= mem_wb_data_i; a_ok_q[i] <= 1'b1;
            end
          end
          if (!b_ok_q[i]) begin
            if (alu_wb_acc && b_tag_q[i] == alu_wb_tag_i) begin
              b_q[i] <= alu_wb_data_i; b_ok_q[i] <= 1'b1;
            end else if (mem_wb_acc && b_tag_q[i] == mem_wb_tag_i) begin
              b_q[i] <= mem_wb_data_i; b_ok_q[i] <= 1'b1;
            end
          end
        end
        // lifecycle
        if (ret_fire && head_idx == IDX_W'(i)) begin
          st_q[i] <= ST_EMPTY;
        end else if (kill_valid_i && kill_mask[i] && st_q[i] != ST_EMPTY) begin
          st_q[i] <= ST_KILL;
        end else if (alu_fire && alu_idx == IDX_W'(i)) begin
          st_q[i] <= ST_DISP;
        end else if (mem_fire && mem_idx == IDX_W'(i)) begin
          st_q[i] <= ST_DISP;
        end else if (alu_wb_acc && alu_wb_tag_i == IDX_W'(i)) begin
          st_q[i]  <= ST_DONE;
          res_q[i] <= alu_wb_data_i;
        end else if (mem_wb_acc && mem_wb_tag_i == IDX_W'(i)) begin
          st_q[i]  <= ST_DONE;
          res_q[i] <= mem_wb_data_i;
        end
        if (ins_fire && tail_idx == IDX_W'(i)) begin
          st_q[i]    <= ST_WAIT;
          mem_q[i]   <= ins_mem_i;
          op_q[i]    <= ins_op_i;
          dst_q[i]   <= ins_dst_i;
          a_q[i]     <= cap_a;
          a_ok_q[i]  <= cap_a_ok;
          a_tag_q[i] <= ins_a_tag_i;
          b_q[i]     <= cap_b;
          b_ok_q[i]  <= cap_b_ok;
          b_tag_q[i] <= ins_b_tag_i;
        end
      end
    end
  end

  // Assertions
  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= PTR_W'(DEPTH));

  assert_alu_pick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_valid_o |-> (st_q[alu_tag_o] == ST_WAIT) && a_ok_q[alu_tag_o] &&
                    b_ok_q[alu_tag_o] && !mem_q[alu_tag_o]);

  assert_alu_leaves_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_fire |=> st_q[$past(alu_tag_o)] != ST_WAIT);

  assert_mem_pick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (st_q[mem_tag_o] == ST_WAIT) && a_ok_q[mem_tag_o] &&
                    b_ok_q[mem_tag_o] && mem_q[mem_tag_o]);

  assert_full_blocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && full) |=> tail_q == $past(tail_q));

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    assert_done_from_disp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[g] == ST_DONE && $past(st_q[g]) != ST_DONE) |-> $past(st_q[g]) == ST_DISP);
    assert_kill_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[g] == ST_KILL) |=> (st_q[g] == ST_KILL || st_q[g] == ST_EMPTY));
  end

endmodule

// File: tb/rob_core_test.sv
`timescale 1ns/1ps
module rob_core_test;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             ins_valid = 0, ins_ready, ins_mem = 0, ins_a_ok = 0, ins_b_ok = 0;
  logic [IDX_W-1:0] ins_tag, ins_a_tag = 0, ins_b_tag = 0;
  logic [7:0]       ins_op = 0;
  logic [4:0]       ins_dst = 0;
  logic [31:0]      ins_a = 0, ins_b = 0;
  logic             alu_valid, alu_ready = 0, mem_valid, mem_ready = 0;
  logic [IDX_W-1:0] alu_tag, mem_tag;
  logic [7:0]       alu_op, mem_op;
  logic [31:0]      alu_a, alu_b, mem_a, mem_b;
  logic             alu_wb_valid = 0, mem_wb_valid = 0, kill_valid = 0;
  logic [IDX_W-1:0] alu_wb_tag = 0, mem_wb_tag = 0, kill_tag = 0;
  logic [31:0]      alu_wb_data = 0, mem_wb_data = 0;
  logic             ret_valid, ret_ready = 0, ret_we;
  logic [4:0]       ret_dst;
  logic [31:0]      ret_data;

  rob_core uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ins_valid_i(ins_valid), .ins_ready_o(ins_ready), .ins_tag_o(ins_tag),
    .ins_op_i(ins_op), .ins_mem_i(ins_mem), .ins_dst_i(ins_dst),
    .ins_a_i(ins_a), .ins_a_ok_i(ins_a_ok), .ins_a_tag_i(ins_a_tag),
    .ins_b_i(ins_b), .ins_b_ok_i(ins_b_ok), .ins_b_tag_i(ins_b_tag),
    .alu_valid_o(alu_valid), .alu_ready_i(alu_ready), .alu_tag_o(alu_tag),
    .alu_op_o(alu_op), .alu_a_o(alu_a), .alu_b_o(alu_b),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_tag_o(mem_tag),
    .mem_op_o(mem_op), .mem_a_o(mem_a), .mem_b_o(mem_b),
    .alu_wb_valid_i(alu_wb_valid), .alu_wb_tag_i(alu_wb_tag), .alu_wb_data_i(alu_wb_data),
    .mem_wb_valid_i(mem_wb_valid), .mem_wb_tag_i(mem_wb_tag), .mem_wb_data_i(mem_wb_data),
    .kill_valid_i(kill_valid), .kill_tag_i(kill_tag),
    .ret_valid_o(ret_valid), .ret_ready_i(ret_ready), .ret_we_o(ret_we),
    .ret_dst_o(ret_dst), .ret_data_o(ret_data)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct { logic we; logic [4:0] dst; logic [31:0] data; } exp_t;
  exp_t sb_q[$];
  exp_t mon_e;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Retirement monitor (scoreboard side, R7/R8)
  always @(negedge clk) begin
    if (rst_n && ret_valid && ret_ready) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected retirement actual_we=%0h expected=none", ret_we);
      end else begin
        mon_e = sb_q.pop_front();
        if (ret_we !== mon_e.we ||
            (mon_e.we && (ret_dst !== mon_e.dst || ret_data !== mon_e.data))) begin
          errors++;
          $display("FAIL R7/R8 retire actual=%0h/%0h/%0h expected=%0h/%0h/%0h",
                   ret_we, ret_dst, ret_data, mon_e.we, mon_e.dst, mon_e.data);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Driver: inserts and records the expected retirement
  task automatic do_ins(input logic [7:0] op, input logic m, input logic [4:0] dst,
                        input logic [31:0] a, input logic aok, input logic [3:0] atag,
                        input logic [31:0] b, input logic bok, input logic [3:0] btag,
                        input logic [3:0] etag, input logic ewe, input logic [31:0] edata);
    exp_t e;
    @(negedge clk);
    chk("R2 ins_ready", 32'(ins_ready), 32'd1);
    chk("R2 tag", 32'(ins_tag), 32'(etag));
    ins_op = op; ins_mem = m; ins_dst = dst;
    ins_a = a; ins_a_ok = aok; ins_a_tag = atag;
    ins_b = b; ins_b_ok = bok; ins_b_tag = btag;
    ins_valid = 1'b1;
    e.we = ewe; e.dst = dst; e.data = edata;
    sb_q.push_back(e);
    @(posedge clk); #1;
    ins_valid = 1'b0;
  endtask

  task automatic alu_take(input string req, input logic [3:0] t, input logic [31:0] a,
                          input logic [31:0] b);
    @(negedge clk);
    chk({req, " alu_valid"}, 32'(alu_valid), 32'd1);
    chk({req, " alu_tag"}, 32'(alu_tag), 32'(t));
    chk({req, " alu_a"}, alu_a, a);
    chk({req, " alu_b"}, alu_b, b);
    alu_ready = 1'b1;
    @(posedge clk); #1;
    alu_ready = 1'b0;
  endtask

  task automatic alu_wb(input logic [3:0] t, input logic [31:0] d);
    @(negedge clk);
    alu_wb_valid = 1'b1; alu_wb_tag = t; alu_wb_data = d;
    @(posedge clk); #1;
    alu_wb_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    @(negedge clk);
    chk("R1 ins_ready", 32'(ins_ready), 32'd1);
    chk("R1 alu_valid", 32'(alu_valid), 32'd0);
    chk("R1 mem_valid", 32'(mem_valid), 32'd0);
    chk("R1 ret_valid", 32'(ret_valid), 32'd0);

    // I0 alu 3+4, I1 mem 10^6, I2 alu waits on tag 0
    do_ins(8'h01, 0, 5'd1, 32'd3, 1, 4'd0, 32'd4, 1, 4'd0, 4'd0, 1, 32'd7);
    do_ins(8'h02, 1, 5'd2, 32'd10, 1, 4'd0, 32'd6, 1, 4'd0, 4'd1, 1, 32'd12);
    do_ins(8'h03, 0, 5'd3, 32'd0, 0, 4'd0, 32'd5, 1, 4'd0, 4'd2, 1, 32'd12);

    @(negedge clk);
    chk("R3 alu_valid", 32'(alu_valid), 32'd1);
    chk("R3 alu_tag", 32'(alu_tag), 32'd0);
    chk("R3 alu_op", 32'(alu_op), 32'h01);
    chk("R3 alu_a", alu_a, 32'd3);
    chk("R3 alu_b", alu_b, 32'd4);
    chk("R4 mem_valid", 32'(mem_valid), 32'd1);
    chk("R4 mem_tag", 32'(mem_tag), 32'd1);
    chk("R4 mem_op", 32'(mem_op), 32'h02);
    chk("R4 mem_a", mem_a, 32'd10);
    chk("R4 mem_b", mem_b, 32'd6);
    alu_ready = 1'b1; mem_ready = 1'b1;
    @(posedge clk); #1;
    alu_ready = 1'b0; mem_ready = 1'b0;

    // dispatched entries not re-offered; I2 still waits; stale write to waiting I2
    @(negedge clk);
    chk("R3 no reoffer / R6 wait", 32'(alu_valid), 32'd0);
    chk("R4 no reoffer", 32'(mem_valid), 32'd0);
    alu_wb_valid = 1'b1; alu_wb_tag = 4'd2; alu_wb_data = 32'd99;
    @(posedge clk); #1;
    alu_wb_valid = 1'b0;

    // both units write back in one cycle
    @(negedge clk);
    alu_wb_valid = 1'b1; alu_wb_tag = 4'd0; alu_wb_data = 32'd7;
    mem_wb_valid = 1'b1; mem_wb_tag = 4'd1; mem_wb_data = 32'd12;
    @(posedge clk); #1;
    alu_wb_valid = 1'b0; mem_wb_valid = 1'b0;

    @(negedge clk);
    chk("R7 ret_valid", 32'(ret_valid), 32'd1);
    chk("R7 ret_we", 32'(ret_we), 32'd1);
    chk("R7 ret_dst", 32'(ret_dst), 32'd1);
    chk("R7 ret_data", ret_data, 32'd7);
    // R5: I2 ignored the stale write, R6: broadcast filled operand A
    alu_take("R6 broadcast", 4'd2, 32'd7, 32'd5);
    alu_wb(4'd2, 32'd12);

    // R6 capture from done producer at insert; branch I4; younger I5, I6
    do_ins(8'h04, 0, 5'd4, 32'd0, 0, 4'd2, 32'd1, 1, 4'd0, 4'd3, 1, 32'd13);
    do_ins(8'h05, 0, 5'd5, 32'd1, 1, 4'd0, 32'd1, 1, 4'd0, 4'd4, 1, 32'd2);
    do_ins(8'h06, 0, 5'd6, 32'd2, 1, 4'd0, 32'd2, 1, 4'd0, 4'd5, 0, 32'd0);
    do_ins(8'h07, 1, 5'd7, 32'd3, 1, 4'd0, 32'd3, 1, 4'd0, 4'd6, 0, 32'd0);

    alu_take("R6 insert capture", 4'd3, 32'd12, 32'd1);
    alu_wb(4'd3, 32'd13);
    alu_take("R3 oldest", 4'd4, 32'd1, 32'd1);
    alu_take("R3 oldest", 4'd5, 32'd2, 32'd2);
    @(negedge clk);
    chk("R4 mem offer", 32'(mem_tag), 32'd6);
    kill_valid = 1'b1; kill_tag = 4'd4;
    @(posedge clk); #1;
    kill_valid = 1'b0;

    @(negedge clk);
    chk("R8 killed mem not offered", 32'(mem_valid), 32'd0);
    chk("R8 nothing offered", 32'(alu_valid), 32'd0);
    alu_wb(4'd5, 32'd77);   // killed: must be ignored
    alu_wb(4'd4, 32'd2);    // branch itself survives

    @(negedge clk);
    ret_ready = 1'b1;
    repeat (12) @(negedge clk);
    chk("R7 drained", 32'(sb_q.size()), 32'd0);
    chk("R7 ret idle", 32'(ret_valid), 32'd0);

    // R2: fill across the wrap, head = tail = 7
    for (int k = 0; k < 16; k++)
      do_ins(8'h10, 0, 5'(8 + k), 32'(k), 1, 4'd0, 32'd100, 1, 4'd0,
             4'((7 + k) % 16), 1, 32'(k + 100));
    @(negedge clk);
    chk("R2 full", 32'(ins_ready), 32'd0);
    ins_valid = 1'b1; ins_op = 8'hEE; ins_dst = 5'd31; ins_a_ok = 1; ins_b_ok = 1;
    @(posedge clk); #1;
    ins_valid = 1'b0;

    for (int k = 0; k < 16; k++) begin
      alu_take("R2 R3 wrap order", 4'((7 + k) % 16), 32'(k), 32'd100);
      alu_wb(4'((7 + k) % 16), 32'(k + 100));
    end
    repeat (5) @(negedge clk);
    chk("R2 refused insert left nothing", 32'(sb_q.size()), 32'd0);
    chk("R2 no extra retire", 32'(ret_valid), 32'd0);
    chk("R2 no extra dispatch", 32'(alu_valid), 32'd0);
    chk("R2 ready again", 32'(ins_ready), 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule